// File: doc/BRIEF.md
# Interrupt Register Bank

This block holds the interrupt registers of a peripheral: a state word, an enable word and a test word, one bit per interrupt source. The number of sources is a parameter, and a parameter mask marks each source as an event source or a status source. Event sources deliver single-cycle pulses that latch into the state word until software clears them. Status sources deliver levels, and their state bits follow those levels.

Software reaches the bank through a simple register port. A request carries a valid flag, a write flag, a byte address and write data. Read data comes back on the cycle after the request, with a response-valid flag. The block drives one registered interrupt line per source, equal to the state bit masked by its enable bit.

The test word lets software force state bits high. On an event source a test write sets the bit once, and the bit then stays set like any latched event. On a status source the forced value persists until software writes 0 to the same test bit.

Top module: `intr_csr_bank`

## Requirements
- R1: After a synchronous reset, every state bit, every enable bit, every interrupt output, the read data and the response flag are 0.
- R2: The register stride in bytes is (DATA_W+7)/8. The state word sits at offset 0, enable at one stride and test at two strides. A read returns its data with rsp_valid_o high on the cycle after the request, and bits at or above NUM_SRC read as 0.
- R3: For an event source, a high input pulse sets its state bit on the next clock edge, and the bit stays set after the pulse ends.
- R4: For an event source, writing 1 to its state bit clears it, and writing 0 leaves it unchanged.
- R5: If an event pulse and a write-1-to-clear reach the same event bit in one cycle, the bit ends up set.
- R6: For a status source, the state bit equals the input level registered once, and writes to the state word do not change it.
- R7: The enable word is read/write, and its bits at or above NUM_SRC are ignored.
- R8: Each interrupt output equals the AND of its state bit and its enable bit as they stood one cycle earlier.
- R9: Writing 1 to an event source's test bit sets its state bit once. The bit then remains set until it is cleared by write-1-to-clear.
- R10: Writing 1 to a status source's test bit holds its state bit high, whatever the input level, until 0 is written to that test bit.
- R11: A read of the test word returns 0.
- R12: A read of an offset that maps to no register, including a misaligned offset, returns 0. A write to such an offset changes neither the state word nor the enable word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_irq_i | input | NUM_SRC | Per-source input: a pulse for event sources, a level for status sources |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | ADDR_W | Byte address of the access |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata_o | output | DATA_W | Read data |
| irq_o | output | NUM_SRC | Registered, masked interrupt outputs |

## Verification
Several rules are checked by the assertions on every cycle. An event pulse always leaves its state bit set, even under a simultaneous clear. A status bit follows its level or its test hold. Each output tracks the previous cycle's state AND enable. The test word always reads back 0. An access to an undefined offset never disturbs the enable word. Other behaviour appears only in the bench's scenarios: the register offsets and read latency, the difference in persistence between a one-shot event test write and a held status test write, the masking of unused high bits, and the outputs reacting to real sequences of enables and events.

// File: rtl/intr_bank_pkg.sv
package intr_bank_pkg;
  // Read source selected by the address decoder
  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_STATE  = 2'd1,
    RD_ENABLE = 2'd2
  } rd_sel_e;

  // Byte distance between neighbouring registers
  function automatic int unsigned word_stride(input int unsigned width);
    return (width + 7) / 8;
  endfunction
endpackage

// File: rtl/intr_bank_decode.sv
module intr_bank_decode
  import intr_bank_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              wr_state_o,
  output logic              wr_enable_o,
  output logic              wr_test_o,
  output rd_sel_e           rd_sel_o
);
  localparam int unsigned STRIDE = word_stride(DATA_W);
  localparam logic [ADDR_W-1:0] OFF_STATE  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_ENABLE = ADDR_W'(STRIDE);
  localparam logic [ADDR_W-1:0] OFF_TEST   = ADDR_W'(2 * STRIDE);

  logic hit_state, hit_enable, hit_test;

  always_comb begin
    hit_state  = req_valid_i && (req_addr_i == OFF_STATE);
    hit_enable = req_valid_i && (req_addr_i == OFF_ENABLE);
    hit_test   = req_valid_i && (req_addr_i == OFF_TEST);
    wr_state_o  = hit_state  && req_write_i;
    wr_enable_o = hit_enable && req_write_i;
    wr_test_o   = hit_test   && req_write_i;
    if (hit_state && !req_write_i)       rd_sel_o = RD_STATE;
    else if (hit_enable && !req_write_i) rd_sel_o = RD_ENABLE;
    else                                 rd_sel_o = RD_NONE;
  end

  // R12
  wr_strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_state_o, wr_enable_o, wr_test_o}));
endmodule

// File: rtl/intr_src_cell.sv
module intr_src_cell #(
  parameter bit IS_STATUS = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic hw_in,
  input  logic clr_wr,
  input  logic test_wr,
  input  logic test_bit,
  output logic state_o
);
  logic state_q;

  if (IS_STATUS) begin : g_status
    logic hold_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        state_q <= 1'b0;
        hold_q  <= 1'b0;
      end else begin
        state_q <= hw_in | (test_wr ? test_bit : hold_q);
        if (test_wr) hold_q <= test_bit;
      end
    end

    // R6
    status_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (hw_in && clr_wr) |=> state_q);
    // R10
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (hold_q && !test_wr) |=> state_q);
  end else begin : g_event
    always_ff @(posedge clk) begin
      if (rst) state_q <= 1'b0;
      else     state_q <= hw_in | (test_wr & test_bit) | (state_q & ~clr_wr);
    end

    // R5
    event_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      hw_in |=> state_q);
    // R4
    event_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_wr && !hw_in && !(test_wr && test_bit)) |=> !state_q);
  end

  assign state_o = state_q;
endmodule

// File: rtl/intr_csr_bank.sv
module intr_csr_bank
  import intr_bank_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 6,
  parameter logic [NUM_SRC-1:0] STATUS_MASK = NUM_SRC'('hF0)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] hw_irq_i,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  output logic               rsp_valid_o,
  output logic [DATA_W-1:0]  rsp_rdata_o,
  output logic [NUM_SRC-1:0] irq_o
);
  localparam int unsigned STRIDE = word_stride(DATA_W);
  localparam logic [ADDR_W-1:0] CHK_TEST = ADDR_W'(2 * STRIDE);

  logic               wr_state, wr_enable, wr_test;
  rd_sel_e            rd_sel;
  logic [NUM_SRC-1:0] state_vec;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] irq_q;
  logic [NUM_SRC-1:0] wbits;
  logic [DATA_W-1:0]  rdata_q;
  logic               rvalid_q;

  assign wbits = req_wdata_i[NUM_SRC-1:0];

  if (NUM_SRC < DATA_W) begin : g_hi
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^req_wdata_i[DATA_W-1:NUM_SRC];
  end

  intr_bank_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dec_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .wr_state_o  (wr_state),
    .wr_enable_o (wr_enable),
    .wr_test_o   (wr_test),
    .rd_sel_o    (rd_sel)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    intr_src_cell #(.IS_STATUS(STATUS_MASK[i])) cell_i (
      .clk      (clk),
      .rst      (rst),
      .hw_in    (hw_irq_i[i]),
      .clr_wr   (wr_state & wbits[i]),
      .test_wr  (wr_test),
      .test_bit (wbits[i]),
      .state_o  (state_vec[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      irq_q    <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (wr_enable) en_q <= wbits;
      irq_q    <= state_vec & en_q;
      rvalid_q <= req_valid_i & ~req_write_i;
      case (rd_sel)
        RD_STATE:  rdata_q <= DATA_W'(state_vec);
        RD_ENABLE: rdata_q <= DATA_W'(en_q);
        default:   rdata_q <= '0;
      endcase
    end
  end

  assign irq_o       = irq_q;
  assign rsp_rdata_o = rdata_q;
  assign rsp_valid_o = rvalid_q;

  logic known_addr;
  assign known_addr = (req_addr_i == ADDR_W'(0)) || (req_addr_i == ADDR_W'(STRIDE)) ||
                      (req_addr_i == CHK_TEST);

  // R8
  irq_tracks_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == $past(state_vec & en_q));
  // R11
  test_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && !req_write_i && req_addr_i == CHK_TEST) |=> (rsp_valid_o && rsp_rdata_o == '0));
  // R7
  enable_write_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_write_i && req_addr_i == ADDR_W'(STRIDE)) |=> en_q == $past(wbits));
  // R12
  undef_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && !known_addr) |=> en_q == $past(en_q));
endmodule

// File: tb/intr_csr_bank_tb.sv
module intr_csr_bank_tb_top;
  localparam int unsigned NS = 8;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0] hw_irq = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [NS-1:0] irq;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];
  logic [NS-1:0] status_lvl = '0;

  always #5 clk = ~clk;

  intr_csr_bank #(.NUM_SRC(NS), .DATA_W(DW), .ADDR_W(AW), .STATUS_MASK(8'hF0)) dut_i (
    .clk(clk), .rst(rst), .hw_irq_i(hw_irq), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata), .irq_o(irq));

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse(input logic [NS-1:0] p);
    hw_irq = status_lvl | p;
    @(negedge clk);
    hw_irq = status_lvl;
  endtask

  task automatic set_level(input logic [NS-1:0] l);
    status_lvl = l; hw_irq = l;
  endtask

  // Monitor: pops the scoreboard when read data appears
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected response", rsp_rdata, '0);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(rsp_rdata === e, t, rsp_rdata, e);
      end
    end
  end

  bit done = 1'b0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(irq === '0, "R1 irq reset", DW'(irq), '0);
    check(rsp_valid === 1'b0, "R1 rsp_valid reset", DW'(rsp_valid), '0);
    check(rsp_rdata === '0, "R1 rdata reset", rsp_rdata, '0);
    rst = 1'b0;
    tick();
    bus_read(6'd0, 32'h0, "R1 state after reset");
    bus_read(6'd4, 32'h0, "R1 enable after reset");

    // R7 enable readback, high bits dropped; R2 offsets
    bus_write(6'd4, 32'hFFFF_FFFF);
    bus_read(6'd4, 32'h0000_00FF, "R7 enable readback masked");

    // R3 event latch
    pulse(8'h05);
    bus_read(6'd0, 32'h05, "R3 event latched");
    check(irq === 8'h05, "R8 irq after event", DW'(irq), 32'h05);
    tick();
    bus_read(6'd0, 32'h05, "R3 event sticky");

    // R4 write-1-to-clear
    bus_write(6'd0, 32'h01);
    bus_read(6'd0, 32'h04, "R4 w1c clears only bit0");

    // R5 hardware set wins over clear
    hw_irq = 8'h04; req_valid = 1'b1; req_write = 1'b1; req_addr = 6'd0; req_wdata = 32'h04;
    @(negedge clk);
    hw_irq = '0; req_valid = 1'b0; req_write = 1'b0;
    bus_read(6'd0, 32'h04, "R5 set wins");
    bus_write(6'd0, 32'h04);
    bus_read(6'd0, 32'h00, "R4 cleared");

    // R6 status follows level, ignores writes
    set_level(8'h30);
    tick();
    bus_read(6'd0, 32'h30, "R6 status follows");
    bus_write(6'd0, 32'hFF);
    bus_read(6'd0, 32'h30, "R6 status ignores w1c");
    set_level(8'h00);
    tick();
    bus_read(6'd0, 32'h00, "R6 status drops");

    // R8 masking
    bus_write(6'd4, 32'h0F);
    set_level(8'h10);
    tick(); tick();
    check(irq === 8'h00, "R8 masked status", DW'(irq), 32'h0);
    bus_write(6'd4, 32'hFF);
    tick();
    check(irq === 8'h10, "R8 enabled status", DW'(irq), 32'h10);
    set_level(8'h00);
    tick(); tick();
    check(irq === 8'h00, "R8 irq drops", DW'(irq), 32'h0);

    // R9 event test one-shot
    bus_write(6'd8, 32'h02);
    bus_read(6'd0, 32'h02, "R9 test sets event");
    tick(); tick();
    bus_read(6'd0, 32'h02, "R9 event test stays latched");
    bus_write(6'd0, 32'h02);
    bus_read(6'd0, 32'h00, "R9 event cleared by w1c");

    // R10 status test hold
    bus_write(6'd8, 32'h40);
    bus_read(6'd0, 32'h40, "R10 status forced");
    bus_read(6'd8, 32'h00, "R11 test reads zero");
    tick(); tick(); tick();
    bus_read(6'd0, 32'h40, "R10 status held");
    bus_write(6'd0, 32'h40);
    bus_read(6'd0, 32'h40, "R10 hold survives w1c");
    bus_write(6'd8, 32'h00);
    bus_read(6'd0, 32'h00, "R10 hold released");

    // R12 undefined offsets
    bus_write(6'd12, 32'h0);
    bus_write(6'd5, 32'h0);
    bus_write(6'd1, 32'hFF);
    bus_read(6'd4, 32'hFF, "R12 enable untouched");
    bus_read(6'd0, 32'h00, "R12 state untouched");
    bus_read(6'd12, 32'h00, "R12 undefined reads zero");
    bus_read(6'd2, 32'h00, "R12 misaligned reads zero");
    tick();
    check(exp_q.size() == 0, "R2 all reads answered", DW'(exp_q.size()), '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule